// File: doc/BRIEF.md
# Two-Window Overlay Blender

This block merges two windows into one 24-bit RGB output pixel. Window 0 is the lower, primary plane. Window 1 is the upper plane, sized for a cursor or a small overlay. For every screen position it receives the current x/y coordinate and the raw 32-bit word that each window's fetch path offers for that position. From the configuration of each window it decides whether the window covers the point. It then decodes the word according to the window's pixel format, chooses an alpha for the upper window and blends the upper window over the lower one.

A window is configured with an enable, a top-left position, a size and a format code. Window 1 also has a color key with a compare value and a per-bit ignore mask. A pixel that matches the key is made fully transparent. The blend runs in two register stages, so each result appears a fixed two cycles after its inputs. A valid flag travels with the data.

Top module: `ovl_blender`

## Requirements
- R1: Window w covers the screen point (x, y) only when it is enabled and pos_x ≤ x ≤ end_x and pos_y ≤ y ≤ end_y. The inclusive end is pos + size − 1.
- R2: When pos + size is zero, the end coordinate is 0 and does not wrap. A zero size at a nonzero position covers nothing. A zero size at position 0 covers coordinate 0 only.
- R3: Format codes for 32-bit colour words. Byte 3 is bits 31:24, byte 0 is bits 7:0, and X marks an ignored byte.
  - 1 = X,R,G,B
  - 2 = X,B,G,R
  - 3 = R,G,B,X
  - 4 = B,G,R,X
  - 5 = A,R,G,B
  - 6 = A,B,G,R
  - 7 = R,G,B,A
  - 8 = B,G,R,A
- R4: Format code 0 is a 16-bit word in bits 15:0: R in 15:11, G in 10:5, B in 4:0. Each field is widened to 8 bits by repeating its top bits in the low bits.
- R5: Codes 5 to 8 take the blend alpha from the pixel's A byte. All other codes use the fixed opaque alpha 0xFF.
- R6: Any format code above 8 is decoded like code 1.
- R7: Window 1 alone has a color key. When key_en_i is set and the decoded RGB of window 1 equals key_color_i (R in 23:16, G in 15:8, B in 7:0) in every bit where key_mask_i is 0, window 1 gets the transparent alpha 0x00. Window 0 is never keyed.
- R8: A point covered by neither window outputs black. A point covered only by window 0 outputs window 0's colour unchanged.
- R9: Each output channel is round(a·top + (255 − a)·bottom) / 255), where a is window 1's alpha and bottom is window 0's colour, or black when window 0 does not cover the point.
- R10: pixel_o and pix_valid_o reflect the inputs that were present exactly two rising clock edges earlier.
- R11: While rst is high, pixel_o and pix_valid_o are cleared to zero on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid_i | input | 1 | Inputs carry a pixel this cycle |
| scr_x_i | input | COORD_W | Screen x of the current pixel |
| scr_y_i | input | COORD_W | Screen y of the current pixel |
| win_en_i | input | 2 | Per-window enable, bit w for window w |
| win_x_i | input | 2×COORD_W | Per-window left position |
| win_y_i | input | 2×COORD_W | Per-window top position |
| win_w_i | input | 2×COORD_W | Per-window width |
| win_h_i | input | 2×COORD_W | Per-window height |
| win_fmt_i | input | 2×4 | Per-window format code |
| win_pix_i | input | 2×32 | Per-window fetched pixel word |
| key_en_i | input | 1 | Color key enable for window 1 |
| key_color_i | input | 24 | Key compare colour |
| key_mask_i | input | 24 | Key bits to ignore (1 = ignore) |
| pix_valid_o | output | 1 | Output pixel valid |
| pixel_o | output | 24 | Blended RGB, R in 23:16 |

## Verification
The assertions check several behaviours on every cycle. The blend stage never leaves the range spanned by its two input colours. An alpha of 0xFF returns the top colour exactly, and an alpha of 0x00 returns the bottom colour exactly. Both windows disabled yields black. The valid flag keeps its two-cycle lag, and reset clears the output. Only the bench scenarios can show the rest: decoding of each format's byte order, the rounding of partial alphas, the inclusive and zero-size rectangle edges, and key matching under a mask, because these depend on specific input values and on a reference model.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [3:0] {
        FMT_RGB565 = 4'd0,
        FMT_XRGB   = 4'd1,
        FMT_XBGR   = 4'd2,
        FMT_RGBX   = 4'd3,
        FMT_BGRX   = 4'd4,
        FMT_ARGB   = 4'd5,
        FMT_ABGR   = 4'd6,
        FMT_RGBA   = 4'd7,
        FMT_BGRA   = 4'd8
    } fmt_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        rgb_t       c;
        logic [7:0] a;
        logic       has_a;
    } texel_t;

    localparam logic [7:0] ALPHA_CLEAR  = 8'h00;
    localparam logic [7:0] ALPHA_OPAQUE = 8'hFF;
    localparam int NUM_CH = 3;

    // round(s / 255) for s <= 255*255, without a divider
    function automatic logic [7:0] div255_round(input logic [15:0] s);
        logic [16:0] t;
        logic [16:0] u;
        t = {1'b0, s} + 17'd128;
        u = t + {8'b0, t[16:8]};
        return u[15:8];
    endfunction

endpackage

// File: rtl/ovl_rect.sv
module ovl_rect #(
    parameter int COORD_W = 12
) (
    input  logic               en_i,
    input  logic [COORD_W-1:0] pos_x_i,
    input  logic [COORD_W-1:0] pos_y_i,
    input  logic [COORD_W-1:0] size_w_i,
    input  logic [COORD_W-1:0] size_h_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    output logic               hit_o
);
    localparam int EW = COORD_W + 1;

    logic [EW-1:0] sum_x, sum_y, end_x, end_y;

    always_comb begin
        sum_x = {1'b0, pos_x_i} + {1'b0, size_w_i};
        sum_y = {1'b0, pos_y_i} + {1'b0, size_h_i};
        // zero sum saturates at 0 instead of wrapping
        end_x = (sum_x == '0) ? '0 : sum_x - EW'(1);
        end_y = (sum_y == '0) ? '0 : sum_y - EW'(1);
        hit_o = en_i
             && ({1'b0, x_i} >= {1'b0, pos_x_i}) && ({1'b0, x_i} <= end_x)
             && ({1'b0, y_i} >= {1'b0, pos_y_i}) && ({1'b0, y_i} <= end_y);
    end
endmodule

// File: rtl/ovl_unpack.sv
module ovl_unpack
    import ovl_pkg::*;
(
    input  logic [3:0]  fmt_i,
    input  logic [31:0] word_i,
    output texel_t      px_o
);
    always_comb begin
        px_o       = '0;
        px_o.a     = ALPHA_OPAQUE;
        px_o.has_a = 1'b0;
        case (fmt_i)
            FMT_RGB565: begin
                px_o.c.r = {word_i[15:11], word_i[15:13]};
                px_o.c.g = {word_i[10:5],  word_i[10:9]};
                px_o.c.b = {word_i[4:0],   word_i[4:2]};
            end
            FMT_XBGR, FMT_ABGR: begin
                px_o.c = {word_i[7:0], word_i[15:8], word_i[23:16]};
            end
            FMT_RGBX, FMT_RGBA: begin
                px_o.c = word_i[31:8];
            end
            FMT_BGRX, FMT_BGRA: begin
                px_o.c = {word_i[15:8], word_i[23:16], word_i[31:24]};
            end
            default: begin
                // xRGB/ARGB and every unknown code
                px_o.c = word_i[23:0];
            end
        endcase
        case (fmt_i)
            FMT_ARGB, FMT_ABGR: begin
                px_o.a     = word_i[31:24];
                px_o.has_a = 1'b1;
            end
            FMT_RGBA, FMT_BGRA: begin
                px_o.a     = word_i[7:0];
                px_o.has_a = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
    import ovl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid_i,
    input  logic [7:0] alpha_i,
    input  rgb_t       top_i,
    input  rgb_t       bot_i,
    output logic       valid_o,
    output rgb_t       pix_o
);
    logic [NUM_CH-1:0][7:0]  top_ch, bot_ch, out_ch;
    logic [NUM_CH-1:0][7:0]  s1_top, s1_bot;
    logic [NUM_CH-1:0][15:0] s1_pt, s1_pb;
    logic [7:0]              s1_alpha;
    logic                    s1_valid;

    assign top_ch = top_i;
    assign bot_ch = bot_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_alpha <= '0;
        end else begin
            s1_valid <= valid_i;
            s1_alpha <= alpha_i;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1_top[c] <= '0;
                    s1_bot[c] <= '0;
                    s1_pt[c]  <= '0;
                    s1_pb[c]  <= '0;
                    out_ch[c] <= '0;
                end else begin
                    s1_top[c] <= top_ch[c];
                    s1_bot[c] <= bot_ch[c];
                    s1_pt[c]  <= {8'b0, alpha_i} * {8'b0, top_ch[c]};
                    s1_pb[c]  <= {8'b0, (ALPHA_OPAQUE - alpha_i)} * {8'b0, bot_ch[c]};
                    out_ch[c] <= div255_round(s1_pt[c] + s1_pb[c]);
                end
            end

            // R9: result stays between the two input colours
            a_r9_bounded: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (out_ch[c] >= (($past(s1_top[c]) < $past(s1_bot[c])) ? $past(s1_top[c]) : $past(s1_bot[c])))
                      && (out_ch[c] <= (($past(s1_top[c]) > $past(s1_bot[c])) ? $past(s1_top[c]) : $past(s1_bot[c]))));
            // R9: full alpha yields the top colour exactly
            a_r9_opaque: assert property (@(posedge clk) disable iff (rst)
                (s1_alpha == ALPHA_OPAQUE) |=> (out_ch[c] == $past(s1_top[c])));
            // R8/R9: zero alpha yields the bottom colour exactly
            a_r8_clear: assert property (@(posedge clk) disable iff (rst)
                (s1_alpha == ALPHA_CLEAR) |=> (out_ch[c] == $past(s1_bot[c])));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= s1_valid;
    end

    assign pix_o = out_ch;
endmodule

// File: rtl/ovl_blender.sv
module ovl_blender
    import ovl_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int NUM_WIN = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           pix_valid_i,
    input  logic [COORD_W-1:0]             scr_x_i,
    input  logic [COORD_W-1:0]             scr_y_i,
    input  logic [NUM_WIN-1:0]             win_en_i,
    input  logic [NUM_WIN-1:0][COORD_W-1:0] win_x_i,
    input  logic [NUM_WIN-1:0][COORD_W-1:0] win_y_i,
    input  logic [NUM_WIN-1:0][COORD_W-1:0] win_w_i,
    input  logic [NUM_WIN-1:0][COORD_W-1:0] win_h_i,
    input  logic [NUM_WIN-1:0][3:0]         win_fmt_i,
    input  logic [NUM_WIN-1:0][31:0]        win_pix_i,
    input  logic                           key_en_i,
    input  logic [23:0]                    key_color_i,
    input  logic [23:0]                    key_mask_i,
    output logic                           pix_valid_o,
    output logic [23:0]                    pixel_o
);
    localparam int TOP = NUM_WIN - 1;

    logic   [NUM_WIN-1:0] hit;
    texel_t               px [NUM_WIN];
    logic                 keyed;
    logic   [7:0]         alpha_top;
    rgb_t                 bottom, blended;

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            ovl_rect #(.COORD_W(COORD_W)) u_rect (
                .en_i    (win_en_i[w]),
                .pos_x_i (win_x_i[w]),
                .pos_y_i (win_y_i[w]),
                .size_w_i(win_w_i[w]),
                .size_h_i(win_h_i[w]),
                .x_i     (scr_x_i),
                .y_i     (scr_y_i),
                .hit_o   (hit[w])
            );
            ovl_unpack u_unpack (
                .fmt_i (win_fmt_i[w]),
                .word_i(win_pix_i[w]),
                .px_o  (px[w])
            );
        end
    endgenerate

    always_comb begin
        // key applies to the upper window only
        keyed = key_en_i && (((px[TOP].c ^ key_color_i) & ~key_mask_i) == 24'd0);
        if (!hit[TOP] || keyed)   alpha_top = ALPHA_CLEAR;
        else if (px[TOP].has_a)   alpha_top = px[TOP].a;
        else                      alpha_top = ALPHA_OPAQUE;
        bottom = hit[0] ? px[0].c : '0;
    end

    ovl_blend u_blend (
        .clk    (clk),
        .rst    (rst),
        .valid_i(pix_valid_i),
        .alpha_i(alpha_top),
        .top_i  (px[TOP].c),
        .bot_i  (bottom),
        .valid_o(pix_valid_o),
        .pix_o  (blended)
    );

    assign pixel_o = blended;

    // R10: valid out trails valid in by two edges
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> $past(pix_valid_i, 2));
    // R8: no enabled window means black
    a_r8_black: assert property (@(posedge clk) disable iff (rst)
        (pix_valid_o && $past(win_en_i == '0, 2) && !$past(rst, 2) && !$past(rst)) |-> (pixel_o == 24'd0));
    // R11: reset clears the outputs
    a_r11_reset: assert property (@(posedge clk)
        rst |=> (pixel_o == 24'd0) && !pix_valid_o);
endmodule

// File: tb/ovl_blender_bench.sv
module ovl_blender_bench;
    localparam int CW = 12;

    logic               clk = 0;
    logic               rst = 1;
    logic               pix_valid_i = 0;
    logic [CW-1:0]      scr_x_i = 0, scr_y_i = 0;
    logic [1:0]         win_en_i = 0;
    logic [1:0][CW-1:0] win_x_i = '0, win_y_i = '0, win_w_i = '0, win_h_i = '0;
    logic [1:0][3:0]    win_fmt_i = '0;
    logic [1:0][31:0]   win_pix_i = '0;
    logic               key_en_i = 0;
    logic [23:0]        key_color_i = 24'hFFFFFF, key_mask_i = 24'h0;
    logic               pix_valid_o;
    logic [23:0]        pixel_o;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ovl_blender #(.COORD_W(CW), .NUM_WIN(2)) u_ovl_blender (
        .clk(clk), .rst(rst), .pix_valid_i(pix_valid_i),
        .scr_x_i(scr_x_i), .scr_y_i(scr_y_i), .win_en_i(win_en_i),
        .win_x_i(win_x_i), .win_y_i(win_y_i), .win_w_i(win_w_i), .win_h_i(win_h_i),
        .win_fmt_i(win_fmt_i), .win_pix_i(win_pix_i),
        .key_en_i(key_en_i), .key_color_i(key_color_i), .key_mask_i(key_mask_i),
        .pix_valid_o(pix_valid_o), .pixel_o(pixel_o)
    );

    typedef struct packed {
        logic [3:0]  f1;
        logic [31:0] p1;
        logic [3:0]  f0;
        logic [31:0] p0;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd1, 32'hAA102030, 4'd1, 32'h00405060},
        '{4'd2, 32'h00112233, 4'd1, 32'h00405060},
        '{4'd3, 32'h11223344, 4'd2, 32'h00405060},
        '{4'd4, 32'h11223344, 4'd3, 32'h40506000},
        '{4'd5, 32'h40FF0000, 4'd0, 32'h0000001F},
        '{4'd6, 32'hC00000FF, 4'd4, 32'h80C0E000},
        '{4'd7, 32'h00FF0080, 4'd1, 32'h00FFFFFF},
        '{4'd8, 32'hFF000000, 4'd1, 32'h00123456}
    };

    function automatic void decode(input logic [3:0] f, input logic [31:0] w,
                                   output logic [23:0] c, output int a);
        logic [7:0] b3, b2, b1, b0;
        b3 = w[31:24]; b2 = w[23:16]; b1 = w[15:8]; b0 = w[7:0];
        a = 255;
        case (f)
            4'd0: c = {w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2]};
            4'd2: c = {b0, b1, b2};
            4'd3: c = {b3, b2, b1};
            4'd4: c = {b1, b2, b3};
            4'd5: begin c = {b2, b1, b0}; a = b3; end
            4'd6: begin c = {b0, b1, b2}; a = b3; end
            4'd7: begin c = {b3, b2, b1}; a = b0; end
            4'd8: begin c = {b1, b2, b3}; a = b0; end
            default: c = {b2, b1, b0};
        endcase
    endfunction

    function automatic bit covers(input int pos, input int size, input int p);
        int hi;
        hi = (pos + size == 0) ? 0 : pos + size - 1;
        return (p >= pos) && (p <= hi);
    endfunction

    function automatic logic [23:0] model();
        logic [23:0] c0, c1, bot, res;
        int a0, a1, a;
        bit h0, h1;
        decode(win_fmt_i[0], win_pix_i[0], c0, a0);
        decode(win_fmt_i[1], win_pix_i[1], c1, a1);
        h0 = win_en_i[0] && covers(win_x_i[0], win_w_i[0], scr_x_i) && covers(win_y_i[0], win_h_i[0], scr_y_i);
        h1 = win_en_i[1] && covers(win_x_i[1], win_w_i[1], scr_x_i) && covers(win_y_i[1], win_h_i[1], scr_y_i);
        a = h1 ? a1 : 0;
        if (key_en_i && (((c1 ^ key_color_i) & ~key_mask_i) == 0)) a = 0;
        bot = h0 ? c0 : 24'd0;
        for (int k = 0; k < 3; k++) begin
            int t, b;
            t = c1[k*8 +: 8];
            b = bot[k*8 +: 8];
            res[k*8 +: 8] = 8'((a * t + (255 - a) * b + 127) / 255);
        end
        return res;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %06h expected %06h", req, act, exp);
        end
    endtask

    // call at a negedge with inputs set; returns at the next negedge after the check
    task automatic go(input string req);
        logic [23:0] exp;
        exp = model();
        pix_valid_i = 1;
        repeat (2) @(posedge clk);
        #1;
        check(req, pixel_o, exp);
        @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        // R11: reset clears outputs even with inputs active
        pix_valid_i = 1;
        win_en_i = 2'b01;
        win_pix_i[0] = 32'h00FFFFFF;
        win_w_i[0] = 12'd100; win_h_i[0] = 12'd100;
        repeat (4) @(negedge clk);
        check("R11 pixel", pixel_o, 24'h0);
        check("R11 valid", {23'd0, pix_valid_o}, 24'd0);
        rst = 0;
        @(negedge clk);

        // common setup: both windows cover (45,35)
        win_en_i = 2'b11;
        win_x_i[0] = 12'd10; win_y_i[0] = 12'd20; win_w_i[0] = 12'd100; win_h_i[0] = 12'd50;
        win_x_i[1] = 12'd40; win_y_i[1] = 12'd30; win_w_i[1] = 12'd16;  win_h_i[1] = 12'd16;
        scr_x_i = 12'd45; scr_y_i = 12'd35;

        // R3 R4 R5 R9: table of format pairs
        foreach (VECS[i]) begin
            win_fmt_i[1] = VECS[i].f1; win_pix_i[1] = VECS[i].p1;
            win_fmt_i[0] = VECS[i].f0; win_pix_i[0] = VECS[i].p0;
            go("R3/R5/R9 table");
        end

        // R3 explicit byte order: code 4 gives B,G,R,X
        win_fmt_i[1] = 4'd4; win_pix_i[1] = 32'h11223344;
        go("R3 bgrx");
        check("R3 bgrx literal", pixel_o, 24'h332211);
        @(negedge clk);

        // R4: 565 expansion
        win_fmt_i[1] = 4'd0; win_pix_i[1] = 32'h00000841;
        go("R4 565");
        check("R4 565 literal", pixel_o, 24'h080808);
        @(negedge clk);

        // R6: unknown code behaves as xRGB, opaque
        win_fmt_i[1] = 4'hF; win_pix_i[1] = 32'h80112233;
        go("R6 fallback");
        check("R6 fallback literal", pixel_o, 24'h112233);
        @(negedge clk);

        // R9: half alpha rounding, RGBA over white
        win_fmt_i[1] = 4'd7; win_pix_i[1] = 32'h00FF0080;
        win_fmt_i[0] = 4'd1; win_pix_i[0] = 32'h00FFFFFF;
        go("R9 rounding");
        check("R9 rounding literal", pixel_o, 24'h7FFF7F);
        @(negedge clk);

        // R1: inclusive edges of window 1, opaque red over blue
        win_fmt_i[1] = 4'd1; win_pix_i[1] = 32'h00FF0000;
        win_fmt_i[0] = 4'd1; win_pix_i[0] = 32'h000000FF;
        scr_x_i = 12'd40; go("R1 left edge");
        scr_x_i = 12'd55; go("R1 right edge");
        check("R1 right edge literal", pixel_o, 24'hFF0000);
        @(negedge clk);
        scr_x_i = 12'd56; go("R1 past edge");
        check("R1 past edge literal", pixel_o, 24'h0000FF);
        @(negedge clk);
        scr_x_i = 12'd45; scr_y_i = 12'd29; go("R1 above");
        scr_y_i = 12'd35;
        win_en_i = 2'b01; go("R1 disabled");
        win_en_i = 2'b11;

        // R2: zero width at nonzero position covers nothing
        win_w_i[1] = 12'd0; scr_x_i = 12'd40; go("R2 zero size");
        check("R2 zero size literal", pixel_o, 24'h0000FF);
        @(negedge clk);
        // R2: zero width at position 0 covers column 0
        win_x_i[1] = 12'd0; win_x_i[0] = 12'd0; scr_x_i = 12'd0; go("R2 origin");
        check("R2 origin literal", pixel_o, 24'hFF0000);
        @(negedge clk);
        win_x_i[1] = 12'd40; win_w_i[1] = 12'd16; win_x_i[0] = 12'd10;

        // R8: no coverage is black, window 0 alone passes through
        scr_x_i = 12'd500; go("R8 none");
        check("R8 none literal", pixel_o, 24'h000000);
        @(negedge clk);
        scr_x_i = 12'd20; win_pix_i[0] = 32'h00ABCDEF; go("R8 bottom only");
        check("R8 bottom only literal", pixel_o, 24'hABCDEF);
        @(negedge clk);
        scr_x_i = 12'd45;

        // R7: default key (white, no mask) hides white top pixel
        key_en_i = 1; key_color_i = 24'hFFFFFF; key_mask_i = 24'h0;
        win_pix_i[1] = 32'h00FFFFFF; go("R7 match");
        check("R7 match literal", pixel_o, 24'hABCDEF);
        @(negedge clk);
        win_pix_i[1] = 32'h00FFFFFE; go("R7 no match");
        check("R7 no match literal", pixel_o, 24'hFFFFFE);
        @(negedge clk);
        key_color_i = 24'h00FF00; key_mask_i = 24'hFF00FF;
        win_pix_i[1] = 32'h0012FF34; go("R7 masked");
        check("R7 masked literal", pixel_o, 24'hABCDEF);
        @(negedge clk);
        // R7: window 0 never keyed, even with matching colour
        win_en_i = 2'b01; win_pix_i[0] = 32'h0012FF34; go("R7 bottom unkeyed");
        check("R7 bottom unkeyed literal", pixel_o, 24'h12FF34);
        @(negedge clk);
        key_en_i = 0; win_en_i = 2'b11;

        // R10: valid latency of two edges
        pix_valid_i = 0;
        repeat (3) @(negedge clk);
        pix_valid_i = 1;
        @(negedge clk);
        pix_valid_i = 0;
        check("R10 after 1 edge", {23'd0, pix_valid_o}, 24'd0);
        @(negedge clk);
        check("R10 after 2 edges", {23'd0, pix_valid_o}, 24'd1);
        @(negedge clk);
        check("R10 after 3 edges", {23'd0, pix_valid_o}, 24'd0);

        done = 1;
        report();
    end
endmodule